// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on a trigger input. A qualifying edge on the selected trigger copies a free-running counter value into a capture register in a single cycle. The same edge raises a capture flag. The trigger is either an external pin or an alternate comparator signal. It passes through a two-stage synchronizer, an optional majority-free noise filter that needs four identical samples, and an edge detector whose polarity is selectable. The flag drives an interrupt request when interrupts are enabled. An interrupt acknowledge or a software clear pulse clears it.

Software reaches the capture register over an 8-bit register bus, one byte at a time. A single 8-bit holding register is shared by reads and writes, so that each 16-bit transfer is atomic.

- **Reads:** reading the low byte also latches the high byte into the holding register. A later high-byte read returns that latched copy.
- **Writes:** a high-byte write only fills the holding register. The low-byte write then commits both bytes together.
- **Write gating:** commits to the capture register happen only while the counter runs in a mode that uses the register as its TOP value.

The register bus has no back-pressure. Every access is taken in the cycle it is presented. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read. The configuration, clear and interrupt pins are plain level or pulse signals.

Top module: `icap_unit`

## Requirements
- R1: With `cfg_rise_edge`=1 only a 0-to-1 change of the selected, conditioned trigger captures; with `cfg_rise_edge`=0 only a 1-to-0 change captures.
- R2: With the filter off, a trigger change applied before clock edge k loads `cnt_value` as sampled at edge k+3 into the capture register and sets `cap_flag` at that same edge.
- R3: `irq_req` is high exactly while `cap_flag`=1 and `cfg_irq_en`=1; a one-cycle pulse on `irq_ack` or on `flag_clr` clears the flag at the next edge.
- R4: A read with `bus_addr_hi`=0 returns capture bits 7:0 and copies bits 15:8 into the holding register; a read with `bus_addr_hi`=1 returns the holding register, even if a capture happened in between; read data is valid one cycle after `bus_rd`.
- R5: A write with `bus_addr_hi`=1 stores the byte in the holding register only; a following write with `bus_addr_hi`=0 while `top_mode`=1 loads {holding, written byte} into the capture register at once.
- R6: A low-byte write while `top_mode`=0 leaves the capture register unchanged.
- R7: `cfg_src_alt`=0 selects `trig_pin` and `cfg_src_alt`=1 selects `trig_alt`; the unselected input has no effect, and changing the selection between inputs of different level can itself produce a capture.
- R8: With `cfg_filter_en`=1 the conditioned level changes only after four consecutive identical synchronized samples, so captures come four cycles later than in R2 and pulses shorter than four cycles produce no capture.
- R9: When a capture and a flag clear (`flag_clr` or `irq_ack`) fall in the same cycle, `cap_flag` stays set.
- R10: After reset the capture register is 0, `cap_flag` and `irq_req` are 0, and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | External capture trigger, asynchronous |
| trig_alt | input | 1 | Alternate comparator trigger, asynchronous |
| cfg_src_alt | input | 1 | 1 selects `trig_alt`, 0 selects `trig_pin` |
| cfg_filter_en | input | 1 | Enables the four-sample noise filter |
| cfg_rise_edge | input | 1 | 1 captures on rising edges, 0 on falling edges |
| cfg_irq_en | input | 1 | Enables the interrupt request |
| top_mode | input | 1 | Counter uses the capture register as TOP; gates writes |
| cnt_value | input | 16 | Free-running counter value |
| bus_addr_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| flag_clr | input | 1 | Software clear of the capture flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cap_flag | output | 1 | Capture flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench checks the exact capture cycle against a running counter, with the filter off and on. A pipeline one stage too short or too long would store a neighbouring count. A filter that does not restart its run on a short pulse would capture on a three-cycle glitch, and the bench looks for that. To test the atomic read, the bench lets a capture land between the low-byte and high-byte reads. A design that reads the high byte live would return the new value instead of the latched one.

The bench also covers these cases:
- **Capture against clear:** a software clear is placed on the very capture cycle. A design that gives the clear priority would drop the flag.
- **Gated writes:** writes are attempted while `top_mode`=0.
- **Source switch:** switching the source to a trigger at a different level must capture. Edges on the deselected input must not.

// File: rtl/icap_pkg.sv
package icap_pkg;
  // Width of the register bus; the capture register is two bus words wide.
  localparam int unsigned BUS_W = 8;
  localparam int unsigned CAP_W = 2 * BUS_W;

  // Polarity codes of the edge detector.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  // Trigger source codes.
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_ALT = 1'b1
  } trig_src_e;

  // Pick the conditioned level the edge detector should see next.
  function automatic logic filt_next(input logic enable, input logic all_hi,
                                     input logic all_lo, input logic cur,
                                     input logic raw);
    if (!enable) return raw;
    if (all_hi) return 1'b1;
    if (all_lo) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/icap_trig_cond.sv
module icap_trig_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILTER_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pin,
  input  logic trig_alt,
  input  logic src_alt,
  input  logic filter_en,
  output logic level_o
);
  import icap_pkg::*;

  localparam int unsigned HIST_W = FILTER_LEN;

  logic raw_sel;
  logic sync_out;
  logic [HIST_W-1:0] hist_q;
  logic level_q;
  logic all_hi, all_lo;

  assign raw_sel = (trig_src_e'(src_alt) == SRC_ALT) ? trig_alt : trig_pin;

  // Synchronizer chain, length chosen by parameter.
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= raw_sel;
      end
      assign sync_out = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], raw_sel};
      end
      assign sync_out = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // Sample history for the noise filter; keeps shifting even when bypassed.
  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= sync_out;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-2:0], sync_out};
      end
    end
  endgenerate

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= filt_next(filter_en, all_hi, all_lo, level_q, sync_out);
  end

  assign level_o = level_q;

  // R8
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && all_hi && !level_q) |=> level_q);

  // R8
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && !all_hi && !all_lo) |=> $stable(level_q));
endmodule

// File: rtl/icap_edge_det.sv
module icap_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic rise_sel,
  output logic strobe_o
);
  import icap_pkg::*;

  logic prev_q;
  logic rose, fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rose = level_i & ~prev_q;
  assign fell = ~level_i & prev_q;

  always_comb begin
    unique case (edge_pol_e'(rise_sel))
      EDGE_RISE: strobe_o = rose;
      EDGE_FALL: strobe_o = fell;
      default:   strobe_o = 1'b0;
    endcase
  end

  // R1
  strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (level_i == rise_sel));
endmodule

// File: rtl/icap_cap_regs.sv
module icap_cap_regs #(
  parameter int unsigned BUS_W = icap_pkg::BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_stb,
  input  logic [2*BUS_W-1:0] cnt_value,
  input  logic               top_mode,
  input  logic               bus_addr_hi,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               flag_clr,
  input  logic               irq_ack,
  input  logic               irq_en,
  output logic               cap_flag,
  output logic               irq_req
);
  localparam int unsigned CAP_W = 2 * BUS_W;

  logic [CAP_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;
  logic [BUS_W-1:0] rdata_q;
  logic             flag_q;
  logic             rd_lo, rd_hi, wr_lo, wr_hi, commit;

  assign rd_lo  = bus_rd & ~bus_addr_hi;
  assign rd_hi  = bus_rd &  bus_addr_hi;
  assign wr_lo  = bus_wr & ~bus_addr_hi;
  assign wr_hi  = bus_wr &  bus_addr_hi;
  assign commit = wr_lo & top_mode;

  // Capture register: a capture takes priority over a software commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_stb) cap_q <= cnt_value;
    else if (commit)  cap_q <= {temp_q, bus_wdata};
  end

  // Shared holding register for both access directions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     temp_q <= '0;
    else if (rd_lo) temp_q <= cap_q[CAP_W-1:BUS_W];
    else if (wr_hi) temp_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_lo) rdata_q <= cap_q[BUS_W-1:0];
    else if (rd_hi) rdata_q <= temp_q;
  end

  // Flag: set wins over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (cap_stb)             flag_q <= 1'b1;
    else if (flag_clr || irq_ack) flag_q <= 1'b0;
  end

  assign bus_rdata = rdata_q;
  assign cap_flag  = flag_q;
  assign irq_req   = flag_q & irq_en;

  // R2
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_q == $past(cnt_value)));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> flag_q);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !cap_stb) |=> !flag_q);

  // R4
  temp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (temp_q == $past(cap_q[CAP_W-1:BUS_W])));

  // R6
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !top_mode && !cap_stb) |=> $stable(cap_q));

  // R5
  wr_hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !cap_stb) |=> $stable(cap_q));
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILTER_LEN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_pin,
  input  logic        trig_alt,
  input  logic        cfg_src_alt,
  input  logic        cfg_filter_en,
  input  logic        cfg_rise_edge,
  input  logic        cfg_irq_en,
  input  logic        top_mode,
  input  logic [15:0] cnt_value,
  input  logic        bus_addr_hi,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        flag_clr,
  input  logic        irq_ack,
  output logic        cap_flag,
  output logic        irq_req
);
  logic level_w;
  logic cap_stb_w;

  icap_trig_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN (FILTER_LEN)
  ) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_pin (trig_pin),
    .trig_alt (trig_alt),
    .src_alt  (cfg_src_alt),
    .filter_en(cfg_filter_en),
    .level_o  (level_w)
  );

  icap_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level_w),
    .rise_sel(cfg_rise_edge),
    .strobe_o(cap_stb_w)
  );

  icap_cap_regs #(
    .BUS_W(8)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_stb    (cap_stb_w),
    .cnt_value  (cnt_value),
    .top_mode   (top_mode),
    .bus_addr_hi(bus_addr_hi),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .flag_clr   (flag_clr),
    .irq_ack    (irq_ack),
    .irq_en     (cfg_irq_en),
    .cap_flag   (cap_flag),
    .irq_req    (irq_req)
  );

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cap_flag && cfg_irq_en));
endmodule

// File: tb/icap_unit_tb.sv
`timescale 1ns/1ps
module icap_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_pin = 1'b0, trig_alt = 1'b0;
  logic cfg_src_alt = 1'b0, cfg_filter_en = 1'b0, cfg_rise_edge = 1'b1;
  logic cfg_irq_en = 1'b0, top_mode = 1'b0;
  logic [15:0] cnt = 16'h0100;
  logic cnt_run = 1'b1;
  logic bus_addr_hi = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic flag_clr = 1'b0, irq_ack = 1'b0;
  logic cap_flag, irq_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (cnt_run) cnt <= cnt + 16'd1;

  icap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .trig_alt(trig_alt),
    .cfg_src_alt(cfg_src_alt), .cfg_filter_en(cfg_filter_en),
    .cfg_rise_edge(cfg_rise_edge), .cfg_irq_en(cfg_irq_en),
    .top_mode(top_mode), .cnt_value(cnt), .bus_addr_hi(bus_addr_hi),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .cap_flag(cap_flag), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic hi, output logic [7:0] d);
    bus_addr_hi = hi; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    bus_addr_hi = hi; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R10 flag", cap_flag, 0);
    check("R10 irq", irq_req, 0);
    check("R10 rdata", bus_rdata, 0);
    rd16(v);
    check("R10 capture reg", v, 0);
  endtask

  // Rising edge with exact latency and counter value (R1, R2).
  task automatic t_rise();
    logic [15:0] c, v;
    cfg_rise_edge = 1'b1; cyc(1);
    trig_pin = 1'b1; c = cnt;
    cyc(3);
    check("R2 no flag before edge k+3", cap_flag, 0);
    cyc(1);
    check("R2 flag at edge k+3", cap_flag, 1);
    rd16(v);
    check("R2 captured count", v, c + 16'd3);
    clr_flag();
  endtask

  // Falling edge ignored under rising polarity, captured under falling (R1).
  task automatic t_fall();
    logic [15:0] c, v;
    trig_pin = 1'b0; cyc(8);
    check("R1 falling ignored in rising mode", cap_flag, 0);
    trig_pin = 1'b1; cyc(8); clr_flag();
    cfg_rise_edge = 1'b0; cyc(2);
    check("R1 polarity change alone no capture", cap_flag, 0);
    trig_pin = 1'b0; c = cnt;
    cyc(4);
    check("R1 falling captured", cap_flag, 1);
    rd16(v);
    check("R1 falling capture value", v, c + 16'd3);
    clr_flag();
    trig_pin = 1'b1; cyc(8);
    check("R1 rising ignored in falling mode", cap_flag, 0);
    cfg_rise_edge = 1'b1; trig_pin = 1'b0; cyc(8); clr_flag();
  endtask

  // Filter adds four cycles and rejects short pulses (R8).
  task automatic t_filter();
    logic [15:0] c, v;
    cfg_filter_en = 1'b1; cyc(8);
    trig_pin = 1'b1; cyc(3); trig_pin = 1'b0;
    cyc(10);
    check("R8 three-cycle glitch rejected", cap_flag, 0);
    trig_pin = 1'b1; c = cnt;
    cyc(7);
    check("R8 no flag before edge k+7", cap_flag, 0);
    cyc(1);
    check("R8 flag at edge k+7", cap_flag, 1);
    rd16(v);
    check("R8 filtered capture value", v, c + 16'd7);
    trig_pin = 1'b0; cyc(8); clr_flag();
    cfg_filter_en = 1'b0; cyc(2);
  endtask

  // Interrupt gating and clear paths (R3).
  task automatic t_irq();
    cfg_irq_en = 1'b0;
    trig_pin = 1'b1; cyc(5);
    check("R3 flag set", cap_flag, 1);
    check("R3 irq masked", irq_req, 0);
    cfg_irq_en = 1'b1; #1;
    check("R3 irq enabled", irq_req, 1);
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    check("R3 ack clears flag", cap_flag, 0);
    check("R3 irq drops", irq_req, 0);
    trig_pin = 1'b0; cyc(2); trig_pin = 1'b1; cyc(5);
    check("R3 flag set again", cap_flag, 1);
    clr_flag();
    check("R3 software clear", cap_flag, 0);
    trig_pin = 1'b0; cyc(5);
  endtask

  // Low read latches high byte; high read returns latched copy (R4).
  task automatic t_atomic_read();
    logic [7:0] lo, hi;
    cnt_run = 1'b0; cnt = 16'hA1B2;
    trig_pin = 1'b1; cyc(6); clr_flag();
    cnt = 16'h3344;
    rd(1'b0, lo);
    check("R4 low byte", lo, 8'hB2);
    trig_pin = 1'b0; cyc(2); trig_pin = 1'b1; cyc(6);
    check("R4 capture between reads", cap_flag, 1);
    rd(1'b1, hi);
    check("R4 high byte from holding reg", hi, 8'hA1);
    rd(1'b0, lo); rd(1'b1, hi);
    check("R4 new value", {hi, lo}, 16'h3344);
    clr_flag(); trig_pin = 1'b0; cyc(5);
    cnt_run = 1'b1;
  endtask

  // Atomic write and gating (R5, R6).
  task automatic t_write();
    logic [15:0] v;
    logic [7:0] lo;
    top_mode = 1'b1;
    wr(1'b1, 8'h5A);
    rd(1'b0, lo);
    check("R5 high write alone no change", lo, 8'h44);
    wr(1'b1, 8'h5A);
    wr(1'b0, 8'hC3);
    rd16(v);
    check("R5 16-bit write", v, 16'h5AC3);
    top_mode = 1'b0;
    wr(1'b1, 8'h11);
    wr(1'b0, 8'h22);
    rd16(v);
    check("R6 write ignored outside TOP mode", v, 16'h5AC3);
  endtask

  // Source select and switch-induced capture (R7).
  task automatic t_source();
    cfg_src_alt = 1'b0; trig_alt = 1'b1; trig_pin = 1'b0; cyc(6); clr_flag();
    check("R7 alt ignored when pin selected", cap_flag, 0);
    cfg_src_alt = 1'b1; cyc(5);
    check("R7 switching source captures", cap_flag, 1);
    clr_flag();
    trig_pin = 1'b1; cyc(6);
    check("R7 pin ignored when alt selected", cap_flag, 0);
    trig_alt = 1'b0; cyc(3); trig_alt = 1'b1; cyc(5);
    check("R7 alt edge captures", cap_flag, 1);
    clr_flag();
    cfg_src_alt = 1'b0; trig_pin = 1'b0; trig_alt = 1'b0; cyc(6); clr_flag();
  endtask

  // Capture and clear in the same cycle (R9).
  task automatic t_collision();
    trig_pin = 1'b1; cyc(3);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    check("R9 capture beats clear", cap_flag, 1);
    clr_flag();
    trig_pin = 1'b0; cyc(2); trig_pin = 1'b1; cyc(3);
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    check("R9 capture beats ack", cap_flag, 1);
    clr_flag(); trig_pin = 1'b0; cyc(5);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_rise();
    t_fall();
    t_filter();
    t_irq();
    t_atomic_read();
    t_write();
    t_source();
    t_collision();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule